// File: doc/BRIEF.md
# Lockstep Redundancy Checker

This block sits at the boundary where two replicated processing channels leave their replicated region. It watches three egress points: peripheral bus, flash and SRAM. On every clock it compares what channel A and channel B present at each point. A single transaction is forwarded to the shared recipient. Each egress point carries a valid bit, an address, write data and a control field from each channel.

A strap input picks the operating mode, and the block captures it only while the power-on reset is active. In lockstep mode the two channels are merged at each egress point. Channel A's transaction is forwarded, and any difference from channel B sets a sticky flag for that point. In decoupled mode all comparison is switched off, and each channel drives its own egress path. A separate functional reset clears the flags but never touches the captured mode.

Top module: `lockstep_checker`

## Requirements
- R1: While `por_n` is low, the mode register loads `strap_lockstep` on every clock edge (1 = lockstep, 0 = decoupled). Once `por_n` is high, changes on the strap have no effect.
- R2: A pulse on `rst_n` alone leaves the captured mode unchanged.
- R3: In lockstep mode, each primary egress (`*_e0_*`) carries channel A's valid, address, write data and control in the same cycle. Each secondary egress (`*_e1_*`) is driven all-zero.
- R4: In decoupled mode, the primary egress carries channel A and the secondary egress carries channel B. No mismatch flag is ever set, and `fault` stays low.
- R5: At a port, a mismatch exists when either channel's valid is high and the two channels differ in valid, address, write data or control. A difference in payload while both valids are low is not a mismatch.
- R6: A per-port mismatch flag rises at the first clock edge after the cycle that shows the mismatch. It then stays high until `rst_n` or `por_n` is asserted, and it reads low during reset.
- R7: Each port's flag responds only to a mismatch at its own port.
- R8: `fault` is high exactly when at least one of the three per-port flags is high.
- R9: A mismatch presented during reset, or at the first clock edge after reset is released, is not flagged. A mismatch still present at the second edge is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; captures the mode strap |
| rst_n | input | 1 | Functional reset, active low, synchronous; clears flags only |
| strap_lockstep | input | 1 | Mode strap: 1 lockstep, 0 decoupled |
| pb_a_valid | input | 1 | Peripheral bus, channel A valid |
| pb_a_addr | input | ADDR_W | Peripheral bus, channel A address |
| pb_a_wdata | input | DATA_W | Peripheral bus, channel A write data |
| pb_a_ctrl | input | CTRL_W | Peripheral bus, channel A control |
| pb_b_valid | input | 1 | Peripheral bus, channel B valid |
| pb_b_addr | input | ADDR_W | Peripheral bus, channel B address |
| pb_b_wdata | input | DATA_W | Peripheral bus, channel B write data |
| pb_b_ctrl | input | CTRL_W | Peripheral bus, channel B control |
| fl_a_valid | input | 1 | Flash, channel A valid |
| fl_a_addr | input | ADDR_W | Flash, channel A address |
| fl_a_wdata | input | DATA_W | Flash, channel A write data |
| fl_a_ctrl | input | CTRL_W | Flash, channel A control |
| fl_b_valid | input | 1 | Flash, channel B valid |
| fl_b_addr | input | ADDR_W | Flash, channel B address |
| fl_b_wdata | input | DATA_W | Flash, channel B write data |
| fl_b_ctrl | input | CTRL_W | Flash, channel B control |
| sr_a_valid | input | 1 | SRAM, channel A valid |
| sr_a_addr | input | ADDR_W | SRAM, channel A address |
| sr_a_wdata | input | DATA_W | SRAM, channel A write data |
| sr_a_ctrl | input | CTRL_W | SRAM, channel A control |
| sr_b_valid | input | 1 | SRAM, channel B valid |
| sr_b_addr | input | ADDR_W | SRAM, channel B address |
| sr_b_wdata | input | DATA_W | SRAM, channel B write data |
| sr_b_ctrl | input | CTRL_W | SRAM, channel B control |
| pb_e0_valid | output | 1 | Peripheral bus primary egress valid |
| pb_e0_addr | output | ADDR_W | Peripheral bus primary egress address |
| pb_e0_wdata | output | DATA_W | Peripheral bus primary egress write data |
| pb_e0_ctrl | output | CTRL_W | Peripheral bus primary egress control |
| pb_e1_valid | output | 1 | Peripheral bus secondary egress valid |
| pb_e1_addr | output | ADDR_W | Peripheral bus secondary egress address |
| pb_e1_wdata | output | DATA_W | Peripheral bus secondary egress write data |
| pb_e1_ctrl | output | CTRL_W | Peripheral bus secondary egress control |
| fl_e0_valid | output | 1 | Flash primary egress valid |
| fl_e0_addr | output | ADDR_W | Flash primary egress address |
| fl_e0_wdata | output | DATA_W | Flash primary egress write data |
| fl_e0_ctrl | output | CTRL_W | Flash primary egress control |
| fl_e1_valid | output | 1 | Flash secondary egress valid |
| fl_e1_addr | output | ADDR_W | Flash secondary egress address |
| fl_e1_wdata | output | DATA_W | Flash secondary egress write data |
| fl_e1_ctrl | output | CTRL_W | Flash secondary egress control |
| sr_e0_valid | output | 1 | SRAM primary egress valid |
| sr_e0_addr | output | ADDR_W | SRAM primary egress address |
| sr_e0_wdata | output | DATA_W | SRAM primary egress write data |
| sr_e0_ctrl | output | CTRL_W | SRAM primary egress control |
| sr_e1_valid | output | 1 | SRAM secondary egress valid |
| sr_e1_addr | output | ADDR_W | SRAM secondary egress address |
| sr_e1_wdata | output | DATA_W | SRAM secondary egress write data |
| sr_e1_ctrl | output | CTRL_W | SRAM secondary egress control |
| mm_pb | output | 1 | Sticky mismatch flag, peripheral bus |
| mm_fl | output | 1 | Sticky mismatch flag, flash |
| mm_sr | output | 1 | Sticky mismatch flag, SRAM |
| fault | output | 1 | Combined fault, OR of the three flags |

## Verification
The bench builds the block with ADDR_W = 12, DATA_W = 16 and CTRL_W = 4. It flips only the top bit of a field in one channel. This shows that a difference in the most significant bit of each field alone raises the flag, and that it is not masked by truncation. The narrow fields keep the vector table readable while still covering all three ports. Two power-on sequences, one with each strap value, exercise both modes. The mode capture is probed by toggling the strap and pulsing the functional reset between them.

// File: rtl/lockstep_checker.sv
module lockstep_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              strap_lockstep,
  input  logic              pb_a_valid,
  input  logic [ADDR_W-1:0] pb_a_addr,
  input  logic [DATA_W-1:0] pb_a_wdata,
  input  logic [CTRL_W-1:0] pb_a_ctrl,
  input  logic              pb_b_valid,
  input  logic [ADDR_W-1:0] pb_b_addr,
  input  logic [DATA_W-1:0] pb_b_wdata,
  input  logic [CTRL_W-1:0] pb_b_ctrl,
  input  logic              fl_a_valid,
  input  logic [ADDR_W-1:0] fl_a_addr,
  input  logic [DATA_W-1:0] fl_a_wdata,
  input  logic [CTRL_W-1:0] fl_a_ctrl,
  input  logic              fl_b_valid,
  input  logic [ADDR_W-1:0] fl_b_addr,
  input  logic [DATA_W-1:0] fl_b_wdata,
  input  logic [CTRL_W-1:0] fl_b_ctrl,
  input  logic              sr_a_valid,
  input  logic [ADDR_W-1:0] sr_a_addr,
  input  logic [DATA_W-1:0] sr_a_wdata,
  input  logic [CTRL_W-1:0] sr_a_ctrl,
  input  logic              sr_b_valid,
  input  logic [ADDR_W-1:0] sr_b_addr,
  input  logic [DATA_W-1:0] sr_b_wdata,
  input  logic [CTRL_W-1:0] sr_b_ctrl,
  output logic              pb_e0_valid,
  output logic [ADDR_W-1:0] pb_e0_addr,
  output logic [DATA_W-1:0] pb_e0_wdata,
  output logic [CTRL_W-1:0] pb_e0_ctrl,
  output logic              pb_e1_valid,
  output logic [ADDR_W-1:0] pb_e1_addr,
  output logic [DATA_W-1:0] pb_e1_wdata,
  output logic [CTRL_W-1:0] pb_e1_ctrl,
  output logic              fl_e0_valid,
  output logic [ADDR_W-1:0] fl_e0_addr,
  output logic [DATA_W-1:0] fl_e0_wdata,
  output logic [CTRL_W-1:0] fl_e0_ctrl,
  output logic              fl_e1_valid,
  output logic [ADDR_W-1:0] fl_e1_addr,
  output logic [DATA_W-1:0] fl_e1_wdata,
  output logic [CTRL_W-1:0] fl_e1_ctrl,
  output logic              sr_e0_valid,
  output logic [ADDR_W-1:0] sr_e0_addr,
  output logic [DATA_W-1:0] sr_e0_wdata,
  output logic [CTRL_W-1:0] sr_e0_ctrl,
  output logic              sr_e1_valid,
  output logic [ADDR_W-1:0] sr_e1_addr,
  output logic [DATA_W-1:0] sr_e1_wdata,
  output logic [CTRL_W-1:0] sr_e1_ctrl,
  output logic              mm_pb,
  output logic              mm_fl,
  output logic              mm_sr,
  output logic              fault
);
  localparam int NPORT = 3;
  localparam int TXN_W = 1 + ADDR_W + DATA_W + CTRL_W;

  logic                        mode_q;
  logic                        arm_q;
  logic [NPORT-1:0]            flag_q;
  logic [NPORT-1:0]            mism;
  logic [NPORT-1:0][TXN_W-1:0] txn_a, txn_b;

  assign txn_a[0] = {pb_a_valid, pb_a_addr, pb_a_wdata, pb_a_ctrl};
  assign txn_b[0] = {pb_b_valid, pb_b_addr, pb_b_wdata, pb_b_ctrl};
  assign txn_a[1] = {fl_a_valid, fl_a_addr, fl_a_wdata, fl_a_ctrl};
  assign txn_b[1] = {fl_b_valid, fl_b_addr, fl_b_wdata, fl_b_ctrl};
  assign txn_a[2] = {sr_a_valid, sr_a_addr, sr_a_wdata, sr_a_ctrl};
  assign txn_b[2] = {sr_b_valid, sr_b_addr, sr_b_wdata, sr_b_ctrl};

  for (genvar i = 0; i < NPORT; i++) begin : g_cmp
    assign mism[i] = (txn_a[i][TXN_W-1] | txn_b[i][TXN_W-1]) && (txn_a[i] != txn_b[i]);
  end

  always_ff @(posedge clk) begin
    if (!por_n) mode_q <= strap_lockstep;
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) begin
      arm_q  <= 1'b0;
      flag_q <= '0;
    end else begin
      arm_q <= 1'b1;
      if (arm_q && mode_q) flag_q <= flag_q | mism;
    end
  end

  assign {pb_e0_valid, pb_e0_addr, pb_e0_wdata, pb_e0_ctrl} = txn_a[0];
  assign {fl_e0_valid, fl_e0_addr, fl_e0_wdata, fl_e0_ctrl} = txn_a[1];
  assign {sr_e0_valid, sr_e0_addr, sr_e0_wdata, sr_e0_ctrl} = txn_a[2];

  assign {pb_e1_valid, pb_e1_addr, pb_e1_wdata, pb_e1_ctrl} = mode_q ? '0 : txn_b[0];
  assign {fl_e1_valid, fl_e1_addr, fl_e1_wdata, fl_e1_ctrl} = mode_q ? '0 : txn_b[1];
  assign {sr_e1_valid, sr_e1_addr, sr_e1_wdata, sr_e1_ctrl} = mode_q ? '0 : txn_b[2];

  assign mm_pb = flag_q[0];
  assign mm_fl = flag_q[1];
  assign mm_sr = flag_q[2];
  assign fault = mode_q & (|flag_q);
endmodule

// File: rtl/lockstep_checker_sva.sv
module lockstep_checker_sva (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       mode_q,
  input logic [2:0] flag_q,
  input logic       fault,
  input logic       pb_a_valid,
  input logic       pb_b_valid,
  input logic       pb_e1_valid,
  input logic       fl_e1_valid,
  input logic       sr_e1_valid
);
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> $stable(mode_q));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    1'b1 |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  a_r4_quiet_decoupled: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !mode_q |-> (flag_q == 3'b000) && !fault);

  a_r3_secondary_idle: assert property (@(posedge clk) disable iff (!por_n)
    mode_q |-> !pb_e1_valid && !fl_e1_valid && !sr_e1_valid);

  a_r5_cause: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(flag_q[0]) |-> $past(pb_a_valid || pb_b_valid));

  a_r8_fault_needs_flag: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    fault |-> (flag_q != 3'b000));
endmodule

bind lockstep_checker lockstep_checker_sva u_sva (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .mode_q(mode_q), .flag_q(flag_q),
  .fault(fault), .pb_a_valid(pb_a_valid), .pb_b_valid(pb_b_valid),
  .pb_e1_valid(pb_e1_valid), .fl_e1_valid(fl_e1_valid), .sr_e1_valid(sr_e1_valid)
);

// File: tb/lockstep_checker_bench.sv
module lockstep_checker_bench;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int NV = 12;
  // {port[1:0], a_valid, b_valid, diff_addr, diff_data, diff_ctrl, expect_flag}
  localparam logic [7:0] VEC [NV] = '{
    8'b00_11_000_0, 8'b00_11_100_1, 8'b00_11_010_1, 8'b00_11_001_1,
    8'b00_10_000_1, 8'b00_01_000_1, 8'b00_00_111_0, 8'b01_11_010_1,
    8'b01_00_001_0, 8'b10_11_001_1, 8'b10_01_000_1, 8'b10_11_000_0
  };

  logic clk = 0, por_n = 0, rst_n = 0, strap = 1;
  logic [2:0] av, bv;
  logic [2:0][AW-1:0] aad, bad;
  logic [2:0][DW-1:0] adt, bdt;
  logic [2:0][CW-1:0] act, bct;
  logic [2:0] e0v, e1v;
  logic [2:0][AW-1:0] e0a, e1a;
  logic [2:0][DW-1:0] e0d, e1d;
  logic [2:0][CW-1:0] e0c, e1c;
  logic mm_pb, mm_fl, mm_sr, fault;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lockstep_checker #(.ADDR_W(AW), .DATA_W(DW), .CTRL_W(CW)) u_lockstep_checker (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .strap_lockstep(strap),
    .pb_a_valid(av[0]), .pb_a_addr(aad[0]), .pb_a_wdata(adt[0]), .pb_a_ctrl(act[0]),
    .pb_b_valid(bv[0]), .pb_b_addr(bad[0]), .pb_b_wdata(bdt[0]), .pb_b_ctrl(bct[0]),
    .fl_a_valid(av[1]), .fl_a_addr(aad[1]), .fl_a_wdata(adt[1]), .fl_a_ctrl(act[1]),
    .fl_b_valid(bv[1]), .fl_b_addr(bad[1]), .fl_b_wdata(bdt[1]), .fl_b_ctrl(bct[1]),
    .sr_a_valid(av[2]), .sr_a_addr(aad[2]), .sr_a_wdata(adt[2]), .sr_a_ctrl(act[2]),
    .sr_b_valid(bv[2]), .sr_b_addr(bad[2]), .sr_b_wdata(bdt[2]), .sr_b_ctrl(bct[2]),
    .pb_e0_valid(e0v[0]), .pb_e0_addr(e0a[0]), .pb_e0_wdata(e0d[0]), .pb_e0_ctrl(e0c[0]),
    .pb_e1_valid(e1v[0]), .pb_e1_addr(e1a[0]), .pb_e1_wdata(e1d[0]), .pb_e1_ctrl(e1c[0]),
    .fl_e0_valid(e0v[1]), .fl_e0_addr(e0a[1]), .fl_e0_wdata(e0d[1]), .fl_e0_ctrl(e0c[1]),
    .fl_e1_valid(e1v[1]), .fl_e1_addr(e1a[1]), .fl_e1_wdata(e1d[1]), .fl_e1_ctrl(e1c[1]),
    .sr_e0_valid(e0v[2]), .sr_e0_addr(e0a[2]), .sr_e0_wdata(e0d[2]), .sr_e0_ctrl(e0c[2]),
    .sr_e1_valid(e1v[2]), .sr_e1_addr(e1a[2]), .sr_e1_wdata(e1d[2]), .sr_e1_ctrl(e1c[2]),
    .mm_pb(mm_pb), .mm_fl(mm_fl), .mm_sr(mm_sr), .fault(fault)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic idle_all();
    for (int p = 0; p < 3; p++) begin
      av[p] = 0; bv[p] = 0;
      aad[p] = AW'(12'h1A0 + p); bad[p] = aad[p];
      adt[p] = DW'(16'h3C00 + p); bdt[p] = adt[p];
      act[p] = CW'(p + 1); bct[p] = act[p];
    end
  endtask

  task automatic drive(input int p, input bit va, input bit vb, input bit da, input bit dd, input bit dc);
    av[p] = va; bv[p] = vb;
    aad[p] = AW'(12'h5A3 + p); bad[p] = aad[p] ^ (da ? AW'(1) << (AW-1) : '0);
    adt[p] = DW'(16'h9E17 + p); bdt[p] = adt[p] ^ (dd ? DW'(1) << (DW-1) : '0);
    act[p] = CW'(4'h6 + p); bct[p] = act[p] ^ (dc ? CW'(1) << (CW-1) : '0);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic func_reset();
    rst_n = 0; cyc(1); rst_n = 1; cyc(2);
  endtask

  task automatic power_on(input bit s);
    por_n = 0; rst_n = 0; strap = s; cyc(2);
    por_n = 1; rst_n = 1; cyc(2);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_all();
    // reset state, lockstep power-on
    por_n = 0; rst_n = 0; strap = 1;
    drive(0, 1, 0, 1, 0, 0);
    cyc(2);
    chk({mm_pb, mm_fl, mm_sr, fault} == 4'b0, "R6 reset clear", {mm_pb, mm_fl, mm_sr, fault}, 0);
    idle_all();
    por_n = 1; rst_n = 1; cyc(2);

    // R1: strap change after power-on ignored; R3 forwarding
    strap = 0;
    drive(1, 1, 1, 0, 0, 0);
    cyc(1);
    chk(e1v == 3'b000 && e1a[1] == 0 && e1d[1] == 0, "R1 strap ignored after por", e1v, 0);
    chk(e0v[1] && e0a[1] == aad[1] && e0d[1] == adt[1] && e0c[1] == act[1], "R3 primary=A", e0a[1], aad[1]);
    chk(e1c[1] == 0, "R3 secondary zero", e1c[1], 0);
    idle_all(); cyc(1);

    // R6 sticky
    drive(0, 1, 1, 0, 1, 0); cyc(1); idle_all(); cyc(4);
    chk(mm_pb && !mm_fl && !mm_sr, "R6 sticky", {mm_pb, mm_fl, mm_sr}, 3'b100);
    // R2: functional reset keeps mode, clears flags
    func_reset();
    chk({mm_pb, mm_fl, mm_sr} == 3'b000, "R6 cleared by rst_n", {mm_pb, mm_fl, mm_sr}, 0);
    drive(2, 1, 1, 0, 0, 0); bv[2] = 1; #1;
    chk(e1v[2] == 1'b0, "R2 mode held over rst_n", e1v[2], 0);
    idle_all(); cyc(1);

    // vector table: R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      automatic int p = int'(VEC[i][7:6]);
      automatic bit ex = VEC[i][0];
      func_reset();
      drive(p, VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      cyc(1); idle_all();
      chk({mm_sr, mm_fl, mm_pb} == (3'(ex) << p), $sformatf("R5 R7 vector %0d", i), {mm_sr, mm_fl, mm_pb}, 3'(ex) << p);
      chk(fault == ex, $sformatf("R8 vector %0d", i), fault, ex);
    end

    // R8 two ports at once
    func_reset();
    drive(1, 1, 0, 0, 0, 0); drive(2, 1, 1, 1, 0, 0); cyc(1); idle_all();
    chk({mm_sr, mm_fl, mm_pb} == 3'b110 && fault, "R8 two ports", {fault, mm_sr, mm_fl, mm_pb}, 4'b1110);

    // R9 blanking
    rst_n = 0; drive(0, 1, 1, 1, 0, 0); cyc(2);
    chk(!mm_pb, "R9 during reset", mm_pb, 0);
    rst_n = 1; cyc(1);
    chk(!mm_pb, "R9 first edge blanked", mm_pb, 0);
    cyc(1);
    chk(mm_pb, "R9 second edge flags", mm_pb, 1);
    idle_all();

    // decoupled power-on: R1 R4
    power_on(0);
    strap = 1;
    for (int p = 0; p < 3; p++) drive(p, 1, 1, p == 0, p == 1, p == 2);
    bv[1] = 0;
    #1;
    chk(e1v == 3'b101 && e1a[0] == bad[0] && e1d[1] == bdt[1] && e1c[2] == bct[2], "R4 secondary=B", e1a[0], bad[0]);
    chk(e0a[0] == aad[0] && e0c[2] == act[2], "R4 primary=A", e0a[0], aad[0]);
    cyc(4);
    chk({mm_sr, mm_fl, mm_pb, fault} == 4'b0, "R4 no flags decoupled", {mm_sr, mm_fl, mm_pb, fault}, 0);
    func_reset();
    chk(e1v == 3'b101, "R1 decoupled captured, R2 held", e1v, 3'b101);
    idle_all(); cyc(1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule